// File: doc/BRIEF.md
# Receive FIFO with Per-Character Error Flags

This block sits between a serial receiver's deserializer and the CPU side of a UART channel. Each completed character is written with three flags: framing error, parity error and break. The flags are kept in the FIFO entry next to the data. The CPU sees the oldest character and its status, and pops it with a read strobe.

The error status has two reporting modes. In per-character mode it shows only the flags of the character at the head of the FIFO. In accumulating mode it is a sticky OR of the flags of every character that has been at the head since the last clear-error command. A character that completes while the FIFO is full is dropped, and this sets a sticky overrun flag.

The block also controls flow. When automatic RTS is enabled and a new start bit arrives while the FIFO is full, the active-low RTS output is forced inactive. This does not change the software RTS bit. RTS becomes active again as soon as a slot frees up. The interrupt request follows either the not-empty flag or the full flag, chosen by a mode input.

Top module: `rx_err_fifo`

## Requirements
- R1: Characters are read out in the order they were written. `rd_data` shows the oldest stored character. `rd_en` removes it. `rd_en` while the FIFO is empty changes nothing.
- R2: `rx_rdy` is 1 when at least one character is stored. `fifo_full` is 1 when DEPTH characters (default 3) are stored.
- R3: A write while `fifo_full` is 1 is discarded, and `st_ovr` is 1 from the next cycle. `st_ovr` stays set until `clr_err` clears it. If a new overrun occurs in the same cycle as `clr_err`, `st_ovr` stays set.
- R4: When `block_mode` is 0, `st_fe`, `st_pe` and `st_brk` equal the flags of the head character, and they are 0 when the FIFO is empty.
- R5: When `block_mode` is 1, each status bit is the OR of that flag over every character that has been at the head since the last `clr_err`, including the current head.
- R6: `clr_err` empties the accumulated status, so in the next cycle the accumulated status reflects only the current head.
- R7: The cycle after `start_det` is high while `fifo_full` is 1 and `auto_rts_en` is 1, `rts_n` is 1 even though `rts_sw` is 1. This does not happen when `auto_rts_en` is 0.
- R8: When the FIFO is not full, `rts_n` is the inverse of `rts_sw`. After an automatic negation, `rts_n` returns to 0 in the same cycle that the count drops below DEPTH, with no change to `rts_sw`.
- R9: `irq` equals `fifo_full` when `irq_on_full` is 1, and equals `rx_rdy` when `irq_on_full` is 0.
- R10: After reset the FIFO is empty, all status bits and `irq` are 0, and `rts_n` is the inverse of `rts_sw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Character completed by the deserializer |
| wr_data | input | DATA_W | Received character |
| wr_fe | input | 1 | Framing error of the character |
| wr_pe | input | 1 | Parity error of the character |
| wr_brk | input | 1 | Break received |
| start_det | input | 1 | Valid start bit detected |
| rd_en | input | 1 | CPU read, pops the head |
| clr_err | input | 1 | Clear accumulated status and overrun |
| block_mode | input | 1 | 1: accumulating status, 0: per-character status |
| auto_rts_en | input | 1 | Enable automatic RTS negation |
| irq_on_full | input | 1 | Interrupt source: 1 full, 0 not-empty |
| rts_sw | input | 1 | Software RTS request |
| rd_data | output | DATA_W | Head character |
| rx_rdy | output | 1 | FIFO not empty |
| fifo_full | output | 1 | FIFO full |
| st_fe | output | 1 | Framing-error status |
| st_pe | output | 1 | Parity-error status |
| st_brk | output | 1 | Break status |
| st_ovr | output | 1 | Sticky overrun |
| rts_n | output | 1 | RTS, active low |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check these rules on every cycle:
- a full FIFO implies not-empty;
- a write into a full FIFO sets overrun, and overrun stays set until cleared;
- accumulated status bits only rise unless cleared;
- per-character status is 0 when the FIFO is empty;
- RTS is active whenever software requests it and the FIFO has room, and it is forced off after a start bit while full;
- the interrupt is quiet when its selected source is low.

Only the bench's scenarios can show that data comes out in order and that dropped characters never appear. The same holds for which characters make up the accumulated OR, and for RTS recovering on the exact cycle that a read frees a slot.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   typedef struct packed {
      logic fe;
      logic pe;
      logic brk;
   } rxf_flags_t;

   localparam int unsigned RXF_FLAG_W = 3;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
   import rxf_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 3,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] din,
   input  rxf_flags_t        fin,
   output logic [DATA_W-1:0] dout,
   output rxf_flags_t        fout,
   output logic [CNT_W-1:0]  count
);
   localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

   logic [DATA_W-1:0] dmem [DEPTH];
   rxf_flags_t        fmem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              do_push, do_pop;

   assign do_push = push && (count != FULL_CNT);
   assign do_pop  = pop  && (count != '0);

   function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
      return (p == LAST_SLOT) ? '0 : p + 1'b1;
   endfunction

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dmem[g] <= '0;
            fmem[g] <= '0;
         end else if (do_push && (wr_ptr == PTR_W'(g))) begin
            dmem[g] <= din;
            fmem[g] <= fin;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= advance(wr_ptr);
         if (do_pop)  rd_ptr <= advance(rd_ptr);
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign dout = dmem[rd_ptr];
   assign fout = fmem[rd_ptr];
endmodule

// File: rtl/rxf_status.sv
module rxf_status
   import rxf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       block_mode,
   input  logic       clr_err,
   input  logic       head_valid,
   input  rxf_flags_t head_flags,
   input  logic       ovr_evt,
   output rxf_flags_t status,
   output logic       ovr
);
   rxf_flags_t head_live;
   rxf_flags_t acc;

   assign head_live = head_valid ? head_flags : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         ovr <= 1'b0;
      end else begin
         acc <= clr_err ? '0 : (acc | head_live);
         if (ovr_evt)      ovr <= 1'b1;
         else if (clr_err) ovr <= 1'b0;
      end
   end

   assign status = block_mode ? (acc | head_live) : head_live;
endmodule

// File: rtl/rxf_flow.sv
module rxf_flow (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_rts_en,
   input  logic start_det,
   input  logic full,
   input  logic rdy,
   input  logic rts_sw,
   input  logic irq_on_full,
   output logic rts_n,
   output logic irq
);
   logic neg_q;
   logic neg_live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) neg_q <= 1'b0;
      else        neg_q <= auto_rts_en && full && (neg_q || start_det);
   end

   assign neg_live = neg_q && full && auto_rts_en;
   assign rts_n    = !(rts_sw && !neg_live);
   assign irq      = irq_on_full ? full : rdy;
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
   import rxf_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_fe,
   input  logic              wr_pe,
   input  logic              wr_brk,
   input  logic              start_det,
   input  logic              rd_en,
   input  logic              clr_err,
   input  logic              block_mode,
   input  logic              auto_rts_en,
   input  logic              irq_on_full,
   input  logic              rts_sw,
   output logic [DATA_W-1:0] rd_data,
   output logic              rx_rdy,
   output logic              fifo_full,
   output logic              st_fe,
   output logic              st_pe,
   output logic              st_brk,
   output logic              st_ovr,
   output logic              rts_n,
   output logic              irq
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rx_err_fifo: DEPTH must be at least 2");
   end
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("rx_err_fifo: DATA_W must be 5 to 9");
   end

   rxf_flags_t       in_flags, head_flags, status;
   logic [CNT_W-1:0] count;

   assign in_flags = '{fe: wr_fe, pe: wr_pe, brk: wr_brk};

   rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_en),
      .pop   (rd_en),
      .din   (wr_data),
      .fin   (in_flags),
      .dout  (rd_data),
      .fout  (head_flags),
      .count (count)
   );

   assign rx_rdy    = (count != '0);
   assign fifo_full = (count == CNT_W'(DEPTH));

   rxf_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .block_mode (block_mode),
      .clr_err    (clr_err),
      .head_valid (rx_rdy),
      .head_flags (head_flags),
      .ovr_evt    (wr_en && fifo_full),
      .status     (status),
      .ovr        (st_ovr)
   );

   assign st_fe  = status.fe;
   assign st_pe  = status.pe;
   assign st_brk = status.brk;

   rxf_flow u_flow (
      .clk         (clk),
      .rst_n       (rst_n),
      .auto_rts_en (auto_rts_en),
      .start_det   (start_det),
      .full        (fifo_full),
      .rdy         (rx_rdy),
      .rts_sw      (rts_sw),
      .irq_on_full (irq_on_full),
      .rts_n       (rts_n),
      .irq         (irq)
   );
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic rd_en,
   input logic clr_err,
   input logic start_det,
   input logic block_mode,
   input logic auto_rts_en,
   input logic irq_on_full,
   input logic rts_sw,
   input logic rx_rdy,
   input logic fifo_full,
   input logic st_fe,
   input logic st_pe,
   input logic st_brk,
   input logic st_ovr,
   input logic rts_n,
   input logic irq
);
   AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> rx_rdy); // R2
   AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full && wr_en && !rd_en |=> fifo_full && st_ovr); // R3
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      st_ovr && !clr_err |=> st_ovr); // R3
   AST_CHAR_EMPTY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      !block_mode && !rx_rdy |-> !st_fe && !st_pe && !st_brk); // R4
   AST_BLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      block_mode && st_fe && !clr_err |=> st_fe || !block_mode); // R5
   AST_RTS_AUTO_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      auto_rts_en && start_det && fifo_full && !rd_en |=> rts_n || !auto_rts_en); // R7
   AST_RTS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      rts_sw && !fifo_full |-> !rts_n); // R8
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_on_full ? !fifo_full : !rx_rdy) |-> !irq); // R9
endmodule

bind rx_err_fifo rx_err_fifo_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .rd_en       (rd_en),
   .clr_err     (clr_err),
   .start_det   (start_det),
   .block_mode  (block_mode),
   .auto_rts_en (auto_rts_en),
   .irq_on_full (irq_on_full),
   .rts_sw      (rts_sw),
   .rx_rdy      (rx_rdy),
   .fifo_full   (fifo_full),
   .st_fe       (st_fe),
   .st_pe       (st_pe),
   .st_brk      (st_brk),
   .st_ovr      (st_ovr),
   .rts_n       (rts_n),
   .irq         (irq)
);

// File: tb/test_rx_err_fifo.sv
module test_rx_err_fifo;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int DEPTH = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 0, wr_fe = 0, wr_pe = 0, wr_brk = 0;
   logic [DW-1:0] wr_data = '0;
   logic start_det = 0, rd_en = 0, clr_err = 0;
   logic block_mode = 0, auto_rts_en = 0, irq_on_full = 0, rts_sw = 1;
   logic [DW-1:0] rd_data;
   logic rx_rdy, fifo_full, st_fe, st_pe, st_brk, st_ovr, rts_n, irq;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [DW-1:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_err_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) i_rx_err_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_fe(wr_fe), .wr_pe(wr_pe), .wr_brk(wr_brk), .start_det(start_det),
      .rd_en(rd_en), .clr_err(clr_err), .block_mode(block_mode),
      .auto_rts_en(auto_rts_en), .irq_on_full(irq_on_full), .rts_sw(rts_sw),
      .rd_data(rd_data), .rx_rdy(rx_rdy), .fifo_full(fifo_full),
      .st_fe(st_fe), .st_pe(st_pe), .st_brk(st_brk), .st_ovr(st_ovr),
      .rts_n(rts_n), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // driver: writes one character, records it in the scoreboard when room exists
   task automatic push_char(input logic [DW-1:0] d, input logic fe, input logic pe, input logic brk);
      wr_en = 1; wr_data = d; wr_fe = fe; wr_pe = pe; wr_brk = brk;
      if (exp_q.size() < DEPTH) exp_q.push_back(d);
      step();
      wr_en = 0; wr_fe = 0; wr_pe = 0; wr_brk = 0;
   endtask

   task automatic pop_char();
      rd_en = 1;
      step();
      rd_en = 0;
   endtask

   // monitor: compares each popped character against the scoreboard (R1)
   always @(negedge clk) begin
      if (rst_n && rd_en && rx_rdy) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R1 act=%0h exp=<none>", rd_data);
         end else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            if (rd_data !== e) begin
               bad++;
               $display("FAIL R1 act=%0h exp=%0h", rd_data, e);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog act=hung exp=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      step(); step();
      rst_n = 1;
      step();
      // R10 reset state
      check("R10 rdy", rx_rdy, 0);
      check("R10 status", {st_fe, st_pe, st_brk, st_ovr, irq}, 0);
      check("R10 rts", rts_n, 0);

      // R1 read while empty is ignored
      pop_char();
      check("R1 empty read", {rx_rdy, fifo_full}, 2'b00);

      // fill with varied flags, character mode
      push_char(8'h41, 1, 0, 0);
      check("R2 rdy one", {rx_rdy, fifo_full}, 2'b10);
      check("R4 head flags", {st_fe, st_pe, st_brk}, 3'b100);
      push_char(8'h42, 0, 1, 0);
      push_char(8'h43, 0, 0, 1);
      check("R2 full", {rx_rdy, fifo_full}, 2'b11);
      check("R4 head unchanged", {st_fe, st_pe, st_brk}, 3'b100);
      check("R3 no ovr yet", st_ovr, 0);

      // R9 interrupt source selection
      check("R9 irq rdy", irq, 1);
      irq_on_full = 1; #1;
      check("R9 irq full", irq, 1);

      // R3 overrun discards character
      push_char(8'h99, 1, 1, 1);
      check("R3 ovr set", st_ovr, 1);
      check("R3 still full", fifo_full, 1);

      // R7 auto RTS negation with auto disabled: no effect
      start_det = 1;
      step();
      check("R7 auto off", rts_n, 0);
      auto_rts_en = 1;
      step();
      start_det = 0;
      check("R7 negated", rts_n, 1);
      step();
      check("R7 held while full", rts_n, 1);

      // R8 restore on read
      pop_char();
      check("R8 restored", rts_n, 0);
      check("R9 irq full off", irq, 0);
      check("R4 second head", {st_fe, st_pe, st_brk}, 3'b010);
      irq_on_full = 0; #1;
      check("R9 irq rdy on", irq, 1);
      pop_char();
      check("R4 third head", {st_fe, st_pe, st_brk}, 3'b001);
      pop_char();
      check("R4 empty clean", {st_fe, st_pe, st_brk}, 3'b000);
      check("R2 empty", rx_rdy, 0);
      check("R3 ovr sticky", st_ovr, 1);

      // R6/R3 clear error
      clr_err = 1;
      step();
      clr_err = 0;
      check("R3 ovr cleared", st_ovr, 0);

      // R5 block mode accumulation
      block_mode = 1;
      push_char(8'h51, 1, 0, 0);
      push_char(8'h52, 0, 1, 0);
      push_char(8'h53, 0, 0, 0);
      check("R5 first head", {st_fe, st_pe, st_brk}, 3'b100);
      pop_char();
      check("R5 accum two", {st_fe, st_pe, st_brk}, 3'b110);
      pop_char();
      check("R5 accum kept", {st_fe, st_pe, st_brk}, 3'b110);
      clr_err = 1;
      step();
      clr_err = 0;
      check("R6 cleared", {st_fe, st_pe, st_brk}, 3'b000);
      push_char(8'h54, 0, 0, 1);
      pop_char();
      check("R5 new head brk", {st_fe, st_pe, st_brk}, 3'b001);
      pop_char();
      check("R5 sticky empty", {st_fe, st_pe, st_brk}, 3'b001);
      check("R1 drained", rx_rdy, 0);
      check("R1 scoreboard empty", exp_q.size(), 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule